// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge and Completion Interface

This block sits between an interrupt distributor and one processor. Each cycle it scans the per-interrupt enable, pending and priority inputs and registers the most urgent candidate. It compares that candidate against a programmable priority mask and against the priority of the interrupt now being serviced, and it drives the processor's interrupt request line from the result. The distributor keeps ownership of the pending bits. When an interrupt is acknowledged, the block pulses a clear request back to the distributor. When a level-sensitive interrupt is completed and its line is still high, the block pulses a set request.

Software talks to the block through a small register port. The port has a control register, a priority mask, an acknowledge register that is read to take an interrupt, an end-of-interrupt register that is written to complete one, the running priority and the highest pending ID. Read data comes back one cycle after the read strobe, and `reg_rvalid_o` marks it. If a read and a write arrive in the same cycle, the read is served and the write is dropped. Nested interrupts are tracked as a chain, kept per interrupt, that records which interrupt each one preempted. Completions may therefore arrive out of order. Completing an interrupt that is not the running one removes it from the chain and leaves the running interrupt unchanged.

Register addresses (`reg_addr_i`): 0 control, 1 priority mask, 2 acknowledge (read), 3 end-of-interrupt (write), 4 running priority (read), 5 highest pending ID (read). ID 1023 means "no interrupt".

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, control reads 0, the priority mask reads 0xF0, running priority reads 0x100, highest pending reads 1023 and `irq_req_o` is low.
- R2: A control write keeps only bit 0 of the data. A priority mask write keeps only bits 7:0.
- R3: Among interrupts that are both enabled and pending, the one with the numerically lowest priority wins. Ties go to the lowest ID. The winner shows in the highest pending register one cycle after the inputs change.
- R4: The winner is reported as highest pending only if its priority is less than or equal to the mask. Otherwise the register reads 1023.
- R5: `irq_req_o` is high exactly when highest pending is not 1023 and its priority is strictly below the running priority.
- R6: While `dist_en_i` or control bit 0 is clear, `irq_req_o` is low and highest pending reads 1023.
- R7: An acknowledge read that finds a qualifying candidate returns that candidate's ID with `reg_rvalid_o`. In the same cycle it pulses `pend_clr_o` with the ID on `clr_id_o`. The running priority then becomes the candidate's priority.
- R8: An acknowledge read returns 1023 and changes no state when there is no candidate, or when the candidate's priority is not below the running priority.
- R9: Completing the running interrupt makes its recorded predecessor the running interrupt. The running priority becomes that predecessor's priority, or 0x100 if the predecessor is 1023.
- R10: Completing an acknowledged interrupt that is not running unlinks it from the chain and leaves the running priority unchanged. A later completion of the running interrupt then skips over the unlinked one.
- R11: A completion write is ignored while no interrupt is running. The completed ID is taken from data bits 9:0.
- R12: When an interrupt is completed, a set request (`pend_set_o` with `set_id_o`) is issued if that interrupt is level-sensitive (`irq_edge_i` bit 0), enabled, its `irq_level_i` line is high and its `irq_tgt_i` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dist_en_i | input | 1 | Global distributor enable |
| irq_en_i | input | NIRQ | Per-interrupt enable |
| irq_pend_i | input | NIRQ | Per-interrupt pending to this processor |
| irq_level_i | input | NIRQ | Current input line level |
| irq_edge_i | input | NIRQ | 1 = edge-sensitive, 0 = level-sensitive |
| irq_tgt_i | input | NIRQ | Interrupt targets this processor |
| irq_prio_i | input | NIRQ*PW | Priority per interrupt, ID i at bits [i*PW +: PW] |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| reg_rvalid_o | output | 1 | Read data valid |
| irq_req_o | output | 1 | Interrupt request to the processor |
| pend_clr_o | output | 1 | Pulse: clear pending of `clr_id_o` |
| clr_id_o | output | IDW | ID to clear |
| pend_set_o | output | 1 | Pulse: set pending of `set_id_o` |
| set_id_o | output | IDW | ID to set |

## Verification
The bound checker watches four things on every cycle. The request line stays low after a cycle with the distributor disabled. Every clear pulse pairs with an acknowledge read whose returned data matches the pulsed ID. A spurious acknowledge never produces a clear. Set pulses only follow completion writes. Winner selection with ties and the mask boundary, nesting order, out-of-order unlinking and level re-pending depend on the history of accesses. Only the bench's scenarios can show those, through the directed chain sequence and a random acknowledge and completion stream checked against a reference model of the chain.

// File: rtl/irq_cpu_if.sv
module irq_cpu_if #(
  parameter int NIRQ = 64,
  parameter int PW   = 8,
  parameter int IDW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dist_en_i,
  input  logic [NIRQ-1:0]   irq_en_i,
  input  logic [NIRQ-1:0]   irq_pend_i,
  input  logic [NIRQ-1:0]   irq_level_i,
  input  logic [NIRQ-1:0]   irq_edge_i,
  input  logic [NIRQ-1:0]   irq_tgt_i,
  input  logic [NIRQ*PW-1:0] irq_prio_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              reg_rvalid_o,
  output logic              irq_req_o,
  output logic              pend_clr_o,
  output logic [IDW-1:0]    clr_id_o,
  output logic              pend_set_o,
  output logic [IDW-1:0]    set_id_o
);
  localparam int LW = (NIRQ > 1) ? $clog2(NIRQ) : 1;
  localparam int RPW = PW + 1;
  localparam logic [IDW-1:0] NONE = IDW'(1023);
  localparam logic [RPW-1:0] IDLE_P = RPW'(1) << PW;
  localparam logic [2:0] A_CTRL = 3'd0, A_MASK = 3'd1, A_ACK = 3'd2,
                         A_EOI = 3'd3, A_RPRI = 3'd4, A_HPEND = 3'd5;

  logic              cpu_en_q;
  logic [PW-1:0]     pmask_q;
  logic [IDW-1:0]    hp_id_q, run_id_q;
  logic [RPW-1:0]    hp_p_q, run_p_q;
  logic [IDW-1:0]    link_q [NIRQ];
  logic [NIRQ-1:0]   act_q;
  logic [PW-1:0]     prio_a [NIRQ];

  logic [RPW-1:0]    bst_p;
  logic [IDW-1:0]    bst_id;

  always_comb begin
    for (int i = 0; i < NIRQ; i++) prio_a[i] = irq_prio_i[i*PW +: PW];
  end

  always_comb begin
    bst_p  = IDLE_P;
    bst_id = NONE;
    for (int i = 0; i < NIRQ; i++)
      if (irq_en_i[i] && irq_pend_i[i] && {1'b0, prio_a[i]} < bst_p) begin
        bst_p  = {1'b0, prio_a[i]};
        bst_id = IDW'(i);
      end
  end

  wire            gate_on  = dist_en_i && cpu_en_q && (bst_p <= {1'b0, pmask_q});
  wire            rd_ack   = reg_rd_i && reg_addr_i == A_ACK;
  wire            ack_ok   = (hp_id_q != NONE) && (hp_p_q < run_p_q);
  wire            wr_go    = reg_wr_i && !reg_rd_i;
  wire [IDW-1:0]  eoi_id   = reg_wdata_i[IDW-1:0];
  wire            eoi_go   = wr_go && reg_addr_i == A_EOI && run_id_q != NONE
                             && eoi_id < IDW'(NIRQ);
  wire [LW-1:0]   hp_idx   = hp_id_q[LW-1:0];
  wire [LW-1:0]   run_idx  = run_id_q[LW-1:0];
  wire [LW-1:0]   eoi_idx  = eoi_id[LW-1:0];
  wire [IDW-1:0]  run_prev = link_q[run_idx];
  wire [IDW-1:0]  eoi_prev = link_q[eoi_idx];
  wire [RPW-1:0]  prev_p   = (run_prev == NONE) ? IDLE_P
                                                : {1'b0, prio_a[run_prev[LW-1:0]]};
  wire            repend   = !irq_edge_i[eoi_idx] && irq_en_i[eoi_idx]
                             && irq_level_i[eoi_idx] && irq_tgt_i[eoi_idx];

  assign irq_req_o = ack_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_en_q     <= 1'b0;
      pmask_q      <= PW'(8'hF0);
      hp_id_q      <= NONE;
      hp_p_q       <= IDLE_P;
      run_id_q     <= NONE;
      run_p_q      <= IDLE_P;
      act_q        <= '0;
      reg_rdata_o  <= '0;
      reg_rvalid_o <= 1'b0;
      pend_clr_o   <= 1'b0;
      clr_id_o     <= NONE;
      pend_set_o   <= 1'b0;
      set_id_o     <= NONE;
      for (int i = 0; i < NIRQ; i++) link_q[i] <= NONE;
    end else begin
      hp_id_q      <= gate_on ? bst_id : NONE;
      hp_p_q       <= gate_on ? bst_p : IDLE_P;
      reg_rvalid_o <= reg_rd_i;
      pend_clr_o   <= 1'b0;
      pend_set_o   <= 1'b0;

      if (wr_go && reg_addr_i == A_CTRL) cpu_en_q <= reg_wdata_i[0];
      if (wr_go && reg_addr_i == A_MASK) pmask_q  <= reg_wdata_i[PW-1:0];

      if (reg_rd_i) begin
        case (reg_addr_i)
          A_CTRL:  reg_rdata_o <= {31'd0, cpu_en_q};
          A_MASK:  reg_rdata_o <= 32'(pmask_q);
          A_ACK:   reg_rdata_o <= ack_ok ? 32'(hp_id_q) : 32'(NONE);
          A_RPRI:  reg_rdata_o <= 32'(run_p_q);
          A_HPEND: reg_rdata_o <= 32'(hp_id_q);
          default: reg_rdata_o <= '0;
        endcase
      end

      if (rd_ack && ack_ok) begin
        pend_clr_o     <= 1'b1;
        clr_id_o       <= hp_id_q;
        link_q[hp_idx] <= run_id_q;
        act_q[hp_idx]  <= 1'b1;
        run_id_q       <= hp_id_q;
        run_p_q        <= hp_p_q;
      end

      if (eoi_go) begin
        if (repend) begin
          pend_set_o <= 1'b1;
          set_id_o   <= eoi_id;
        end
        if (eoi_id == run_id_q) begin
          run_id_q       <= run_prev;
          run_p_q        <= prev_p;
          act_q[run_idx] <= 1'b0;
        end else if (act_q[eoi_idx]) begin
          for (int i = 0; i < NIRQ; i++)
            if (act_q[i] && link_q[i] == eoi_id) link_q[i] <= eoi_prev;
          act_q[eoi_idx] <= 1'b0;
        end
      end
    end
  end
endmodule

module irq_cpu_if_chk #(
  parameter int IDW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dist_en_i,
  input logic           reg_rd_i,
  input logic           reg_wr_i,
  input logic [2:0]     reg_addr_i,
  input logic [31:0]    reg_rdata_o,
  input logic           reg_rvalid_o,
  input logic           irq_req_o,
  input logic           pend_clr_o,
  input logic [IDW-1:0] clr_id_o,
  input logic           pend_set_o
);
  // R6
  no_req_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dist_en_i) |-> !irq_req_o);

  // R7
  clr_matches_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr_o |-> (reg_rvalid_o && reg_rdata_o == 32'(clr_id_o)));

  // R7
  clr_after_ack_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr_o |-> $past(reg_rd_i && reg_addr_i == 3'd2));

  // R8
  spurious_no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rvalid_o && reg_rdata_o == 32'd1023) |-> !pend_clr_o);

  // R12
  set_after_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set_o |-> $past(reg_wr_i && !reg_rd_i && reg_addr_i == 3'd3));
endmodule

bind irq_cpu_if irq_cpu_if_chk #(.IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dist_en_i(dist_en_i), .reg_rd_i(reg_rd_i),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .reg_rvalid_o(reg_rvalid_o), .irq_req_o(irq_req_o), .pend_clr_o(pend_clr_o),
  .clr_id_o(clr_id_o), .pend_set_o(pend_set_o)
);

// File: tb/irq_cpu_if_bench.sv
module irq_cpu_if_bench;
  localparam int N = 64;
  localparam int NONE = 1023;
  localparam int A_CTRL = 0, A_MASK = 1, A_ACK = 2, A_EOI = 3, A_RPRI = 4, A_HPEND = 5;

  logic clk = 1'b0, rst_n = 1'b0, dist_en = 1'b0;
  logic [N-1:0] en = '0, pend = '0, lvl = '0, edg = '1, tgt = '1;
  logic [N*8-1:0] prio = '0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_rvalid, irq_req, pend_clr, pend_set;
  logic [9:0] clr_id, set_id;

  int nchk = 0, nfail = 0;
  int clr_seen, clr_idv, set_seen, set_idv;
  int mrun, mrunp, pm, cen;
  int link_m [N];
  bit act_m [N];

  always #2 clk = ~clk;

  irq_cpu_if u_irq_cpu_if (
    .clk(clk), .rst_n(rst_n), .dist_en_i(dist_en), .irq_en_i(en), .irq_pend_i(pend),
    .irq_level_i(lvl), .irq_edge_i(edg), .irq_tgt_i(tgt), .irq_prio_i(prio),
    .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .reg_rvalid_o(reg_rvalid), .irq_req_o(irq_req),
    .pend_clr_o(pend_clr), .clr_id_o(clr_id), .pend_set_o(pend_set), .set_id_o(set_id)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = a[2:0]; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = int'(reg_rdata);
    clr_seen = int'(pend_clr); clr_idv = int'(clr_id);
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = a[2:0]; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    set_seen = int'(pend_set); set_idv = int'(set_id);
  endtask

  task automatic setp(input int id, input int p);
    prio[id*8 +: 8] = p[7:0];
  endtask

  function automatic int gp(input int id);
    return int'(prio[id*8 +: 8]);
  endfunction

  function automatic int exp_hp();
    int bp = 256, bi = NONE;
    for (int i = 0; i < N; i++)
      if (en[i] && pend[i] && gp(i) < bp) begin bp = gp(i); bi = i; end
    if (!dist_en || cen == 0 || bp > pm) return NONE;
    return bi;
  endfunction

  function automatic int exp_req();
    int h = exp_hp();
    return (h != NONE && gp(h) < mrunp) ? 1 : 0;
  endfunction

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic model_ack(input string req);
    int h = exp_hp();
    int v;
    bit ok = (h != NONE) && (gp(h) < mrunp);
    rd(A_ACK, v);
    check(req, v, ok ? h : NONE);
    check(req, clr_seen, ok ? 1 : 0);
    if (ok) begin
      check(req, clr_idv, h);
      link_m[h] = mrun; act_m[h] = 1'b1; mrun = h; mrunp = gp(h); pend[h] = 1'b0;
    end
    settle();
  endtask

  task automatic model_eoi(input int id);
    wr(A_EOI, id);
    if (mrun != NONE && id < N) begin
      if (id == mrun) begin
        act_m[id] = 1'b0; mrun = link_m[id];
        mrunp = (mrun == NONE) ? 256 : gp(mrun);
      end else if (act_m[id]) begin
        for (int i = 0; i < N; i++) if (act_m[i] && link_m[i] == id) link_m[i] = link_m[id];
        act_m[id] = 1'b0;
      end
    end
    settle();
  endtask

  initial begin
    #800000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'h5eed_1234));
    mrun = NONE; mrunp = 256; pm = 'hF0; cen = 0;
    for (int i = 0; i < N; i++) begin link_m[i] = NONE; act_m[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_req", int'(irq_req), 0);
    rd(A_CTRL, v);  check("R1 ctrl", v, 0);
    rd(A_MASK, v);  check("R1 mask", v, 'hF0);
    rd(A_RPRI, v);  check("R1 running prio", v, 256);
    rd(A_HPEND, v); check("R1 hpend", v, NONE);

    // R2 field widths
    wr(A_CTRL, 'hFFFE); rd(A_CTRL, v); check("R2 ctrl bit0 only", v, 0);
    wr(A_CTRL, 'hFFFF); rd(A_CTRL, v); check("R2 ctrl", v, 1); cen = 1;
    wr(A_MASK, 'h1234); rd(A_MASK, v); check("R2 mask low byte", v, 'h34);
    wr(A_MASK, 'hFF); pm = 'hFF;

    for (int i = 0; i < N; i++) setp(i, 'hC0);
    en = '1;

    // R6 distributor disabled
    pend[7] = 1'b1; settle();
    check("R6 req off", int'(irq_req), 0);
    rd(A_HPEND, v); check("R6 hpend off", v, NONE);
    dist_en = 1'b1; settle();
    check("R5 req on", int'(irq_req), 1);
    wr(A_CTRL, 0); cen = 0; settle();
    check("R6 cpu off req", int'(irq_req), 0);
    rd(A_HPEND, v); check("R6 cpu off hpend", v, NONE);
    wr(A_CTRL, 1); cen = 1; pend = '0;

    // R3 tie and R4 mask boundary
    setp(9, 'h30); setp(5, 'h30); pend[9] = 1'b1; pend[5] = 1'b1; pend[2] = 1'b1; settle();
    rd(A_HPEND, v); check("R3 tie lowest id", v, 5);
    wr(A_MASK, 'h30); settle();
    rd(A_HPEND, v); check("R4 mask equal", v, 5);
    wr(A_MASK, 'h2F); settle();
    rd(A_HPEND, v); check("R4 mask below", v, NONE);
    check("R5 req masked", int'(irq_req), 0);
    wr(A_MASK, 'hFF); pend = '0;
    for (int i = 0; i < N; i++) setp(i, 'hC0);

    // R7 R8 R9 R10 nesting chain
    setp(10, 'h80); pend[10] = 1'b1; settle();
    check("R5 req", int'(irq_req), 1);
    model_ack("R7 ack 10");
    rd(A_RPRI, v); check("R7 running prio", v, 'h80);
    check("R5 req after ack", int'(irq_req), 0);
    model_ack("R8 nothing pending");
    setp(11, 'h90); pend[11] = 1'b1; settle();
    model_ack("R8 not more urgent");
    rd(A_HPEND, v); check("R8 hpend kept", v, 11);
    pend[11] = 1'b0;
    setp(20, 'h40); pend[20] = 1'b1; settle(); model_ack("R7 ack 20");
    setp(30, 'h20); pend[30] = 1'b1; settle(); model_ack("R7 ack 30");
    model_eoi(20);
    rd(A_RPRI, v); check("R10 non-running eoi", v, 'h20);
    model_eoi(30);
    rd(A_RPRI, v); check("R10 skip unlinked, R9 restore", v, 'h80);
    model_eoi(10);
    rd(A_RPRI, v); check("R9 back to idle", v, 256);
    lvl[10] = 1'b1; edg[10] = 1'b0;
    wr(A_EOI, 10); check("R11 eoi while idle", set_seen, 0);
    lvl[10] = 1'b0; edg[10] = 1'b1;

    // R12 level re-pend, R11 low bits
    setp(40, 'h50); edg[40] = 1'b0; lvl[40] = 1'b1; pend[40] = 1'b1; settle();
    model_ack("R7 ack 40");
    wr(A_EOI, 'hFFFF_FC00 | 40);
    check("R12 repend", set_seen, 1);
    check("R12 repend id", set_idv, 40);
    act_m[40] = 1'b0; mrun = NONE; mrunp = 256;
    settle();
    rd(A_RPRI, v); check("R11 low bits complete", v, 256);
    lvl[40] = 1'b0; edg[40] = 1'b1;

    // R3 R4 R5 random selection, nothing running
    for (int it = 0; it < 40; it++) begin
      en = {$urandom, $urandom};
      pend = {$urandom, $urandom} & {$urandom, $urandom};
      for (int i = 0; i < N; i++) setp(i, (it % 2) ? ($urandom % 4) * 16 : $urandom % 256);
      pm = $urandom % 256;
      wr(A_MASK, pm);
      @(negedge clk);
      check("R5 random req", int'(irq_req), exp_req());
      rd(A_HPEND, v); check("R3 R4 random hpend", v, exp_hp());
    end

    // R7 R9 R10 random ack and completion stream
    en = '1; pend = '0; pm = 'hFF; wr(A_MASK, pm);
    for (int i = 0; i < N; i++) setp(i, $urandom % 256);
    settle();
    for (int it = 0; it < 300; it++) begin
      int op = $urandom % 4;
      if (op == 0) begin
        pend[$urandom % N] = 1'b1; settle();
      end else if (op == 1) begin
        model_ack("R7 R8 random ack");
      end else if (op == 2) begin
        model_eoi(mrun == NONE ? 0 : mrun);
      end else begin
        model_eoi($urandom % N);
      end
      rd(A_RPRI, v); check("R9 R10 random running prio", v, mrunp);
      check("R5 random req", int'(irq_req), exp_req());
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule